// File: doc/BRIEF.md
# Cut-Through Receive Chunk Writer

This block sits between a receive MAC and the host-memory write path of a low-latency network adapter. Frame bytes arrive one per cycle. The block packs them into fixed 128-byte chunks. Each chunk holds 120 bytes of frame data followed by 8 bytes of descriptive metadata. As soon as a chunk is full, or the frame ends, the block issues the chunk as a single memory-write request. It does not wait for the rest of the frame. This lets software start on the head of a frame while the tail is still on the wire.

Chunks go into a ring of host memory. The ring is 2 MiB by default, and the slot index wraps to zero after the last slot. The writer never waits for the consumer. If software falls more than one ring length behind, its unread data is overwritten. To let software detect this, each chunk carries a generation number that advances on every wrap, together with its own slot index. The block also compares its own write position with a consumer position that software presents, and raises a lapped flag.

The ring base address is held in a register. That register reloads from its input only between frames, so a change never splits a frame across two bases.

Top module: `rxc_chunk_writer`

## Requirements
- R1: Chunk bytes 0..119 hold frame bytes in arrival order, with byte k at `wr_data_o[8k+7:8k]`. The metadata occupies bytes 120..127, at bits 1023:960.
- R2: `wr_valid_o` is high for exactly one cycle per chunk. It rises in the cycle after the clock edge that accepts either the 120th byte of a chunk or the last byte of a frame.
- R3: Metadata byte 0 is the number of valid data bytes. This is 120 for every chunk except the last of a frame, where it is 1 to 120. Data bytes beyond that count are zero.
- R4: Metadata byte 1 holds the flags. Bit 0 marks end of frame. Bit 1 marks a MAC error and is set only on the last chunk, when `rx_err_i` was high with `rx_last_i`. Bit 2 marks the first chunk of a frame. Bytes 4..5 give the chunk's position within its frame, counting from 0.
- R5: `wr_addr_o` equals the held base plus 128 times the slot index. The slot advances by one per chunk and wraps to 0 after slot RING_BYTES/128 - 1.
- R6: Metadata bytes 2..3 carry the generation of the slot being written, and bytes 6..7 carry the slot index, both zero-extended. The generation increments, modulo 2^GEN_W, each time the slot wraps to 0.
- R7: `cur_idx_o` and `cur_gen_o` give the slot and generation that the next chunk will use.
- R8: The base register loads `ring_base_i` only on edges where no frame is in progress and no byte is offered. A base change during a frame does not affect that frame's chunks.
- R9: One cycle after the inputs settle, `lapped_o` is high exactly when (writer position - consumer position) modulo 2^(GEN_W+IDX_W) exceeds the slot count. Each position is {generation, slot}.
- R10: Cycles with `rx_valid_i` low have no effect. In those cycles the byte, last and error inputs are ignored.
- R11: After reset, `wr_valid_o` is low, the slot and generation are 0, `lapped_o` is low, and the first frame starts in an empty chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base_i | input | ADDR_W | Ring base address, loaded between frames |
| rx_valid_i | input | 1 | A frame byte is offered this cycle |
| rx_byte_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Offered byte is the final byte of its frame |
| rx_err_i | input | 1 | MAC error for the frame, meaningful with rx_last_i |
| sw_idx_i | input | IDX_W | Consumer slot index presented by software |
| sw_gen_i | input | GEN_W | Consumer generation presented by software |
| wr_valid_o | output | 1 | Memory-write request strobe, one per chunk |
| wr_addr_o | output | ADDR_W | Host byte address of the chunk |
| wr_data_o | output | 1024 | Chunk contents, data then metadata |
| cur_idx_o | output | IDX_W | Next slot to be written |
| cur_gen_o | output | GEN_W | Generation of the next slot |
| lapped_o | output | 1 | Writer is more than one ring ahead of the consumer |

## Verification
The hardest states to reach are the generation wrap, which needs the slot to wrap back to 0 many times, and the exact lap boundary at a distance of one full ring. The bench therefore uses an 8-slot ring with a 3-bit generation. A sweep of every frame length from 1 to 250 bytes produces hundreds of chunks, which wraps the generation several times. At three different writer positions, the bench then sweeps the consumer position over distances of 0 to 20 slots behind the writer. Inside frames it inserts bubbles that carry garbage byte, last and error values, and it changes the base in the middle of a frame.

// File: rtl/rxc_pkg.sv
// Shared constants and the metadata layout of a receive chunk.
// Assumes the chunk geometry is fixed: 120 data bytes plus 8 metadata bytes.
package rxc_pkg;
    localparam int CHUNK_BYTES = 128;
    localparam int DATA_BYTES  = 120;
    localparam int META_BYTES  = CHUNK_BYTES - DATA_BYTES;
    localparam int CHUNK_SHIFT = $clog2(CHUNK_BYTES);
    localparam int FILL_W      = $clog2(DATA_BYTES + 1);
    localparam int DATA_W      = DATA_BYTES * 8;
    localparam int META_W      = META_BYTES * 8;
    localparam int CHUNK_W     = CHUNK_BYTES * 8;

    localparam int FLAG_EOF = 0;
    localparam int FLAG_ERR = 1;
    localparam int FLAG_SOF = 2;

    // Byte 0 sits at the least significant end.
    typedef struct packed {
        logic [15:0] slot;    // bytes 6..7
        logic [15:0] part;    // bytes 4..5
        logic [15:0] gen;     // bytes 2..3
        logic [7:0]  flags;   // byte 1
        logic [7:0]  nbytes;  // byte 0
    } chunk_meta_t;
endpackage

// File: rtl/rxc_chunk_asm.sv
// Packs incoming frame bytes into a 120-byte data lane and flags when a chunk
// is complete (full, or the frame ended). The emitted lane already contains
// the byte accepted in the same cycle. Unfilled bytes are zero.
// Assumes one byte per cycle at most; no backpressure.
module rxc_chunk_asm
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [7:0]        byte_i,
    input  logic              last_i,
    input  logic              err_i,
    output logic              emit_o,
    output logic [DATA_W-1:0] lane_o,
    output logic [7:0]        nbytes_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic              err_o,
    output logic [15:0]       part_o,
    output logic              in_frame_o
);
    logic [DATA_W-1:0] acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [15:0]       part_q;
    logic              in_frame_q;
    logic              full_now;

    // Lane merge: each byte position takes the incoming byte when it is the fill point.
    generate
        for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
            assign lane_o[8*k +: 8] = (valid_i && fill_q == FILL_W'(k)) ? byte_i
                                                                        : acc_q[8*k +: 8];
        end
    endgenerate

    // Completion decode for the byte offered this cycle.
    always_comb begin
        full_now   = (fill_q == FILL_W'(DATA_BYTES - 1));
        emit_o     = valid_i && (full_now || last_i);
        nbytes_o   = 8'(fill_q) + 8'd1;
        sof_o      = (part_q == 16'd0);
        eof_o      = last_i;
        err_o      = last_i && err_i;
        part_o     = part_q;
        in_frame_o = in_frame_q;
    end

    // Accumulator, fill count, chunk position and frame-activity state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            fill_q     <= '0;
            part_q     <= '0;
            in_frame_q <= 1'b0;
        end else if (valid_i) begin
            in_frame_q <= !last_i;
            if (emit_o) begin
                acc_q  <= '0;
                fill_q <= '0;
                part_q <= last_i ? 16'd0 : part_q + 16'd1;
            end else begin
                acc_q  <= lane_o;
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxc_ring_ptr.sv
// Ring slot index and generation counter. Advances one slot per issued chunk
// and bumps the generation whenever the slot wraps to zero.
// Assumes the slot count is a power of two, so the index wraps naturally.
module rxc_ring_ptr #(
    parameter int IDX_W = 14,
    parameter int GEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [GEN_W-1:0] gen_o
);
    localparam logic [IDX_W-1:0] LAST_SLOT = '1;

    logic [IDX_W-1:0] idx_q;
    logic [GEN_W-1:0] gen_q;

    // Slot and generation advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            gen_q <= '0;
        end else if (advance_i) begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == LAST_SLOT) begin
                gen_q <= gen_q + GEN_W'(1);
            end
        end
    end

    assign idx_o = idx_q;
    assign gen_o = gen_q;
endmodule

// File: rtl/rxc_lap_detect.sv
// Compares the writer position with a consumer position supplied by software,
// each as {generation, slot}, and flags when the writer leads by more than one ring.
// Assumes software keeps its position at or behind the writer; the distance is modular.
module rxc_lap_detect #(
    parameter int IDX_W = 14,
    parameter int GEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] prod_idx_i,
    input  logic [GEN_W-1:0] prod_gen_i,
    input  logic [IDX_W-1:0] cons_idx_i,
    input  logic [GEN_W-1:0] cons_gen_i,
    output logic             lapped_o
);
    localparam int POS_W = GEN_W + IDX_W;
    localparam logic [POS_W-1:0] RING_SLOTS = POS_W'(1) << IDX_W;

    logic [POS_W-1:0] lead;
    logic             lapped_q;

    // Modular distance of the writer ahead of the consumer.
    assign lead = {prod_gen_i, prod_idx_i} - {cons_gen_i, cons_idx_i};

    // Registered lap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lapped_q <= 1'b0;
        end else begin
            lapped_q <= (lead > RING_SLOTS);
        end
    end

    assign lapped_o = lapped_q;
endmodule

// File: rtl/rxc_chunk_writer.sv
// Cut-through receive chunk writer. Frame bytes are packed into 128-byte chunks
// (120 data + 8 metadata) and each chunk is issued as one host memory write as
// soon as it completes, into a ring of RING_BYTES. The writer never stalls.
// Assumes RING_BYTES is a power of two and a multiple of 128, GEN_W <= 16,
// and the write path accepts a request every cycle.
module rxc_chunk_writer
    import rxc_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int RING_BYTES = 2097152,
    parameter int GEN_W      = 16,
    localparam int SLOTS     = RING_BYTES / CHUNK_BYTES,
    localparam int IDX_W     = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  ring_base_i,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_byte_i,
    input  logic               rx_last_i,
    input  logic               rx_err_i,
    input  logic [IDX_W-1:0]   sw_idx_i,
    input  logic [GEN_W-1:0]   sw_gen_i,
    output logic               wr_valid_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [CHUNK_W-1:0] wr_data_o,
    output logic [IDX_W-1:0]   cur_idx_o,
    output logic [GEN_W-1:0]   cur_gen_o,
    output logic               lapped_o
);
    logic              emit;
    logic [DATA_W-1:0] lane;
    logic [7:0]        nbytes;
    logic              sof, eof, ferr, in_frame;
    logic [15:0]       part;
    logic [IDX_W-1:0]  idx;
    logic [GEN_W-1:0]  gen;
    logic [ADDR_W-1:0] base_q;
    chunk_meta_t       meta;

    logic               wr_valid_q;
    logic [ADDR_W-1:0]  wr_addr_q;
    logic [CHUNK_W-1:0] wr_data_q;

    rxc_chunk_asm u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (rx_valid_i),
        .byte_i     (rx_byte_i),
        .last_i     (rx_last_i),
        .err_i      (rx_err_i),
        .emit_o     (emit),
        .lane_o     (lane),
        .nbytes_o   (nbytes),
        .sof_o      (sof),
        .eof_o      (eof),
        .err_o      (ferr),
        .part_o     (part),
        .in_frame_o (in_frame)
    );

    rxc_ring_ptr #(.IDX_W(IDX_W), .GEN_W(GEN_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (emit),
        .idx_o     (idx),
        .gen_o     (gen)
    );

    rxc_lap_detect #(.IDX_W(IDX_W), .GEN_W(GEN_W)) u_lap (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_idx_i (idx),
        .prod_gen_i (gen),
        .cons_idx_i (sw_idx_i),
        .cons_gen_i (sw_gen_i),
        .lapped_o   (lapped_o)
    );

    // Metadata assembly for the chunk completing this cycle.
    always_comb begin
        meta                 = '0;
        meta.nbytes          = nbytes;
        meta.flags[FLAG_EOF] = eof;
        meta.flags[FLAG_ERR] = ferr;
        meta.flags[FLAG_SOF] = sof;
        meta.gen             = 16'(gen);
        meta.part            = part;
        meta.slot            = 16'(32'(idx));
    end

    // Base register: reloads only between frames with no byte on offer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (!in_frame && !rx_valid_i) begin
            base_q <= ring_base_i;
        end
    end

    // Write request register: one strobe per completed chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= emit;
            if (emit) begin
                wr_addr_q <= base_q + (ADDR_W'(idx) << CHUNK_SHIFT);
                wr_data_q <= {meta, lane};
            end
        end
    end

    assign wr_valid_o = wr_valid_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;
    assign cur_idx_o  = idx;
    assign cur_gen_o  = gen;
endmodule

// File: rtl/rxc_chunk_writer_chk.sv
// Property checker for the chunk writer, bound to every instance of the top.
// Assumes reset is held low from time zero for at least one clock edge.
module rxc_chunk_writer_chk #(
    parameter int IDX_W = 14,
    parameter int GEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid_i,
    input logic             wr_valid_o,
    input logic [1023:0]    wr_data_o,
    input logic [IDX_W-1:0] cur_idx_o,
    input logic [GEN_W-1:0] cur_gen_o
);
    logic [7:0] m_nbytes;
    logic [7:0] m_flags;
    assign m_nbytes = wr_data_o[967:960];
    assign m_flags  = wr_data_o[975:968];

    // R2: a chunk is only issued after a byte was accepted on the previous edge.
    a_r2_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(rx_valid_i));

    // R5: every issued chunk moves the slot on by exactly one.
    a_r5_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> cur_idx_o == IDX_W'($past(cur_idx_o) + 1'b1));

    // R5: without an issued chunk the slot holds.
    a_r5_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_o |-> $stable(cur_idx_o));

    // R6: the generation steps exactly when the slot wraps to zero.
    a_r6_gen_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && cur_idx_o == '0) |-> cur_gen_o == GEN_W'($past(cur_gen_o) + 1'b1));

    a_r6_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && cur_idx_o != '0) |-> $stable(cur_gen_o));

    // R3: the valid count is within 1..120 and is full on any non-final chunk.
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (m_nbytes >= 8'd1 && m_nbytes <= 8'd120));

    a_r3_mid_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !m_flags[0]) |-> m_nbytes == 8'd120);

    // R4: the error flag only appears on a final chunk.
    a_r4_err_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && m_flags[1]) |-> m_flags[0]);

    // R11: the first cycle after reset starts clean.
    a_r11_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wr_valid_o && cur_idx_o == '0 && cur_gen_o == '0));
endmodule

bind rxc_chunk_writer rxc_chunk_writer_chk #(.IDX_W(IDX_W), .GEN_W(GEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid_i (rx_valid_i),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .cur_idx_o  (cur_idx_o),
    .cur_gen_o  (cur_gen_o)
);

// File: tb/rxc_chunk_writer_tb.sv
`timescale 1ns/1ps
// Bench for the chunk writer on an 8-slot ring with a 3-bit generation.
module rxc_chunk_writer_tb;
    localparam int ADDR_W = 32;
    localparam int RING_B = 1024;
    localparam int GEN_W  = 3;
    localparam int IDX_W  = 3;
    localparam int NSLOT  = 8;
    localparam int NPOS   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = 32'h0001_0000;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = 8'h00;
    logic              rx_last = 1'b0;
    logic              rx_err = 1'b0;
    logic [IDX_W-1:0]  sw_idx = '0;
    logic [GEN_W-1:0]  sw_gen = '0;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [1023:0]     wr_data;
    logic [IDX_W-1:0]  cur_idx;
    logic [GEN_W-1:0]  cur_gen;
    logic              lapped;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the ring and the chunk under construction.
    int              m_idx = 0, m_gen = 0, m_fill = 0, m_part = 0;
    logic [31:0]     m_base = 32'h0001_0000;
    logic [1023:0]   m_cur = '0;
    logic [1023:0]   exp_data_q[$];
    logic [31:0]     exp_addr_q[$];
    logic            drv_emit = 1'b0;
    logic            exp_pulse = 1'b0;

    rxc_chunk_writer #(.ADDR_W(ADDR_W), .RING_BYTES(RING_B), .GEN_W(GEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_last_i(rx_last), .rx_err_i(rx_err),
        .sw_idx_i(sw_idx), .sw_gen_i(sw_gen),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .cur_idx_o(cur_idx), .cur_gen_o(cur_gen), .lapped_o(lapped)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [1023:0] got, logic [1023:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected strobe timing: the bench mirrors one register stage.
    always @(posedge clk) exp_pulse <= rst_n ? drv_emit : 1'b0;

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_valid || exp_pulse) check("R2 strobe timing", 1024'(wr_valid), 1024'(exp_pulse));
            if (wr_valid) begin
                if (exp_data_q.size() == 0) begin
                    check("R2 unexpected chunk", 1024'(1), 1024'(0));
                end else begin
                    logic [1023:0] ed;
                    logic [31:0]   ea;
                    ed = exp_data_q.pop_front();
                    ea = exp_addr_q.pop_front();
                    check("R1 data bytes", 1024'(wr_data[959:0]), 1024'(ed[959:0]));
                    check("R3 valid count", 1024'(wr_data[967:960]), 1024'(ed[967:960]));
                    check("R4 flags and chunk position", 1024'({wr_data[1007:992], wr_data[975:968]}),
                          1024'({ed[1007:992], ed[975:968]}));
                    check("R6 generation and slot", 1024'({wr_data[1023:1008], wr_data[991:976]}),
                          1024'({ed[1023:1008], ed[991:976]}));
                    check("R5 address", 1024'(wr_addr), 1024'(ea));
                end
            end
        end
    end

    // Closes the chunk being modelled and queues its expected image.
    task automatic push_chunk(bit eof, bit err);
        logic [7:0] flags;
        flags = {5'b0, (m_part == 0), err, eof};
        m_cur[1023:960] = {16'(m_idx), 16'(m_part), 16'(m_gen), flags, 8'(m_fill)};
        exp_data_q.push_back(m_cur);
        exp_addr_q.push_back(m_base + 32'(m_idx * 128));
        m_idx = (m_idx + 1) % NSLOT;
        if (m_idx == 0) m_gen = (m_gen + 1) % (1 << GEN_W);
        m_part = eof ? 0 : m_part + 1;
        m_fill = 0;
        m_cur  = '0;
    endtask

    // Idle cycles carrying garbage on the ignored inputs (R10).
    task automatic idle(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_byte = 8'hA5; rx_last = 1'b1; rx_err = 1'b1; drv_emit = 1'b0;
        end
    endtask

    task automatic send_frame(int fid, int len, bit err, int bubble_every, int chg_at,
                              logic [31:0] chg_base);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            bit         lst;
            if (bubble_every > 0 && i > 0 && (i % bubble_every) == 0) idle(1);
            @(negedge clk);
            if (i == chg_at) ring_base = chg_base;
            b   = 8'((fid * 37 + i * 11 + 5) & 255);
            lst = (i == len - 1);
            rx_valid = 1'b1; rx_byte = b; rx_last = lst;
            rx_err   = lst ? err : 1'b1;
            m_cur[8*m_fill +: 8] = b;
            m_fill++;
            drv_emit = (m_fill == 120) || lst;
            if (drv_emit) push_chunk(lst, lst && err);
        end
    endtask

    task automatic check_ptr(string tag);
        check({"R7 next slot ", tag}, 1024'(cur_idx), 1024'(m_idx));
        check({"R7 next generation ", tag}, 1024'(cur_gen), 1024'(m_gen));
    endtask

    // R9: consumer distance swept across the one-ring boundary.
    task automatic lap_sweep();
        int p;
        p = m_gen * NSLOT + m_idx;
        for (int d = 0; d <= 20; d++) begin
            int c;
            c = (p - d) & (NPOS - 1);
            @(negedge clk);
            sw_idx = IDX_W'(c % NSLOT);
            sw_gen = GEN_W'(c / NSLOT);
            @(negedge clk);
            check("R9 lap flag", 1024'(lapped), 1024'(d > NSLOT));
        end
        @(negedge clk);
        sw_idx = IDX_W'(m_idx);
        sw_gen = GEN_W'(m_gen);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(1_500_000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: clean state right after reset.
        check("R11 strobe low", 1024'(wr_valid), 1024'(0));
        check("R11 slot zero", 1024'(cur_idx), 1024'(0));
        check("R11 generation zero", 1024'(cur_gen), 1024'(0));
        check("R11 lap flag low", 1024'(lapped), 1024'(0));
        idle(2);

        // Boundary lengths around one and two chunks, with and without error.
        send_frame(1, 1, 1'b0, 0, -1, 0);    idle(2); check_ptr("len1");
        send_frame(2, 119, 1'b1, 0, -1, 0);  idle(2); check_ptr("len119");
        send_frame(3, 120, 1'b0, 0, -1, 0);  idle(2); check_ptr("len120");
        send_frame(4, 121, 1'b1, 0, -1, 0);  idle(2); check_ptr("len121");
        send_frame(5, 240, 1'b0, 7, -1, 0);  idle(2); check_ptr("len240");
        send_frame(6, 241, 1'b1, 0, -1, 0);  idle(2); check_ptr("len241");
        lap_sweep();

        // R8: base change mid-frame applies only after the frame ends.
        send_frame(7, 200, 1'b0, 0, 130, 32'h0002_0040);
        idle(2);
        m_base = 32'h0002_0040;
        send_frame(8, 50, 1'b0, 0, -1, 0);
        idle(2); check_ptr("after base change");

        // Sweep of every length, mixing errors, bubbles and back-to-back frames.
        for (int len = 1; len <= 250; len++) begin
            send_frame(100 + len, len, (len % 7) == 0, ((len % 5) == 3) ? 17 : 0, -1, 0);
            if ((len % 4) != 0) idle(1);
        end
        idle(3);
        check_ptr("after sweep");
        lap_sweep();
        send_frame(999, 37, 1'b0, 3, -1, 0);
        idle(3);
        lap_sweep();
        check("R2 all chunks issued", 1024'(exp_data_q.size()), 1024'(0));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule